// File: doc/BRIEF.md
# DMA Controller Control-Port Register Block

This block decodes the eight control-port writes of a four-channel DMA controller. It holds the state those writes act on: the command byte, a 4-bit channel mask, an 8-bit status byte, four 8-bit channel mode bytes and the byte pointer. The byte pointer selects the low or high half of the 16-bit channel-register accesses. The channel address and count registers, and the transfer scheduler, sit outside this block. The scheduler reads the mask, status and mode outputs to decide which channels may run.

In the status byte, the low nibble holds one terminal-count flag per channel and the high nibble holds one request flag per channel. A software request write and the external hold/release strobes both drive the request flags. The terminal-count flags are set by strobes from the channel logic. The command register accepts only its block-controller bit, bit 2. A command write that carries any other set bit is refused and raises a one-cycle error pulse.

All state updates on the rising clock edge that samples the write or strobe. Outputs show the new value from that edge on.

Top module: `dma_ctl_regs`

## Requirements
- R1: While rst_n is low and after it rises, status is 0x00, mask is 0xF, command is 0x00, every mode byte is 0x00, byte_ptr is 0 and cmd_err is 0.
- R2: A write to port 0 (command) with data in which only bit 2 may be set loads command. Any other set bit leaves command unchanged and drives cmd_err high for exactly the one cycle after that edge. Command therefore never holds a bit other than bit 2.
- R3: A write to port 1 (software request) takes the channel n from data[1:0]. It sets status bit 4+n when data[2]=1 and clears it when data[2]=0. In both cases it clears status bit n.
- R4: A write to port 2 (single mask) takes the channel n from data[1:0]. It sets mask bit n when data[2]=1 and clears it when data[2]=0. The other mask bits are untouched.
- R5: A write to port 3 (mode) stores the whole data byte into the mode byte of channel data[1:0], at mode_flat[8n+7:8n]. The other mode bytes are untouched. Inside a mode byte, [3:2] is the transfer type, bit 4 is auto-init, bit 5 is decrement and [7:6] is the operating mode.
- R6: A ptr_toggle pulse inverts byte_ptr. A write to port 4 (clear byte pointer) forces byte_ptr to 0 and takes precedence over a toggle in the same cycle.
- R7: A write to port 5 (master reset) clears byte_ptr, status and command and sets all four mask bits. The mode bytes are kept.
- R8: A write to port 6 zeroes the mask. A write to port 7 loads the mask from data[3:0].
- R9: hold_req[n] sets status bit 4+n and release_req[n] clears it. When both occur in the same cycle, the release wins. Both strobes act after any port write in that cycle, including a request write and a master reset.
- R10: tc_set[n] sets status bit n, acting after any port write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control-port write strobe |
| wr_port | input | 3 | Control port: 0 command, 1 request, 2 single mask, 3 mode, 4 clear pointer, 5 master reset, 6 clear masks, 7 write masks |
| wr_data | input | 8 | Write data byte |
| hold_req | input | 4 | Per-channel request-hold strobes |
| release_req | input | 4 | Per-channel request-release strobes |
| tc_set | input | 4 | Per-channel terminal-count strobes |
| ptr_toggle | input | 1 | Byte-pointer toggle from a channel-register access |
| status | output | 8 | [7:4] request flags, [3:0] terminal-count flags |
| mask | output | 4 | Channel mask, 1 = masked |
| command | output | 8 | Accepted command byte |
| mode_flat | output | 32 | Four mode bytes, channel n at [8n+7:8n] |
| byte_ptr | output | 1 | Byte pointer |
| cmd_err | output | 1 | One-cycle pulse after a refused command write |

## Verification
The assertions check on every cycle the properties that need only one edge of history. These are: command never holds an unsupported bit; an error pulse always follows a refused command write; a release always wins over a hold; a whole-mask write, a mode write and a master reset take effect on the next edge. The ordering between a port write and the strobes of the same cycle shows only in the bench's scenarios. The same holds for the terminal-count flags being cleared by a request write and for the mode bytes surviving a master reset. The bench's cycle-by-cycle reference model compares every output in every cycle across those scenarios.

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_port,
  input  logic [DW-1:0]     wr_data,
  input  logic [NCH-1:0]    hold_req,
  input  logic [NCH-1:0]    release_req,
  input  logic [NCH-1:0]    tc_set,
  input  logic              ptr_toggle,
  output logic [2*NCH-1:0]  status,
  output logic [NCH-1:0]    mask,
  output logic [DW-1:0]     command,
  output logic [NCH*DW-1:0] mode_flat,
  output logic              byte_ptr,
  output logic              cmd_err
);
  localparam logic [DW-1:0] CMD_OK = DW'(4);

  logic [2*NCH-1:0] st_q, st_d;
  logic [NCH-1:0]   mask_q;
  logic [DW-1:0]    cmd_q;
  logic [DW-1:0]    mode_q [NCH];
  logic             ptr_q, err_q;

  wire [1:0] ch     = wr_data[1:0];
  wire       w_cmd  = wr_en && wr_port == 3'd0;
  wire       w_req  = wr_en && wr_port == 3'd1;
  wire       w_smsk = wr_en && wr_port == 3'd2;
  wire       w_mode = wr_en && wr_port == 3'd3;
  wire       w_clrp = wr_en && wr_port == 3'd4;
  wire       w_mrst = wr_en && wr_port == 3'd5;
  wire       w_clrm = wr_en && wr_port == 3'd6;
  wire       w_allm = wr_en && wr_port == 3'd7;
  wire       bad    = (wr_data & ~CMD_OK) != '0;

  always_comb begin
    st_d = st_q;
    if (w_req) begin
      st_d[NCH + int'(ch)] = wr_data[2];
      st_d[ch] = 1'b0;
    end
    if (w_mrst) st_d = '0;
    st_d[NCH-1:0]     = st_d[NCH-1:0] | tc_set;
    st_d[2*NCH-1:NCH] = (st_d[2*NCH-1:NCH] | hold_req) & ~release_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= '0;
      mask_q <= '1;
      cmd_q  <= '0;
      ptr_q  <= 1'b0;
      err_q  <= 1'b0;
      for (int i = 0; i < NCH; i++) mode_q[i] <= '0;
    end else begin
      st_q  <= st_d;
      err_q <= w_cmd && bad;
      if (w_cmd && !bad) cmd_q <= wr_data;
      if (w_mrst) cmd_q <= '0;
      if (w_clrp || w_mrst) ptr_q <= 1'b0;
      else if (ptr_toggle) ptr_q <= ~ptr_q;
      if (w_smsk) mask_q[ch] <= wr_data[2];
      if (w_clrm) mask_q <= '0;
      if (w_allm) mask_q <= wr_data[NCH-1:0];
      if (w_mrst) mask_q <= '1;
      if (w_mode) mode_q[ch] <= wr_data;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_mode
    assign mode_flat[g*DW +: DW] = mode_q[g];
  end

  assign status   = st_q;
  assign mask     = mask_q;
  assign command  = cmd_q;
  assign byte_ptr = ptr_q;
  assign cmd_err  = err_q;
endmodule

module dma_ctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_port,
  input logic [7:0]  wr_data,
  input logic [3:0]  hold_req,
  input logic [3:0]  release_req,
  input logic        ptr_toggle,
  input logic [7:0]  status,
  input logic [3:0]  mask,
  input logic [7:0]  command,
  input logic [31:0] mode_flat,
  input logic        byte_ptr,
  input logic        cmd_err
);
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (command & 8'hFB) == 8'h00); // R2
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_port == 3'd0 && (wr_data & 8'hFB) != 8'h00) |=> cmd_err); // R2
  AST_ERR_ONLY_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_port != 3'd0) |=> !cmd_err); // R2
  AST_RELEASE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (release_req != 4'h0) |=> ((status[7:4] & $past(release_req)) == 4'h0)); // R9
  AST_HOLD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ((hold_req & ~release_req) != 4'h0) |=>
      ((status[7:4] & $past(hold_req & ~release_req)) == $past(hold_req & ~release_req))); // R9
  AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_port == 3'd7) |=> mask == $past(wr_data[3:0])); // R8
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_port == 3'd3) |=> mode_flat[8*$past(wr_data[1:0]) +: 8] == $past(wr_data)); // R5
  AST_MASTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_port == 3'd5) |=> (mask == 4'hF && command == 8'h00 && !byte_ptr)); // R7
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_port == 3'd4) |=> !byte_ptr); // R6
endmodule

bind dma_ctl_regs dma_ctl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
  .hold_req(hold_req), .release_req(release_req), .ptr_toggle(ptr_toggle),
  .status(status), .mask(mask), .command(command), .mode_flat(mode_flat),
  .byte_ptr(byte_ptr), .cmd_err(cmd_err)
);

// File: tb/dma_ctl_regs_tb.sv
module dma_ctl_regs_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0, ptr_toggle = 0;
  logic [2:0] wr_port = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] hold_req = 0, release_req = 0, tc_set = 0;
  logic [7:0] status, command;
  logic [3:0] mask;
  logic [31:0] mode_flat;
  logic byte_ptr, cmd_err;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_ctl_regs dut_i (.*);

  int m_stat, m_mask, m_cmd, m_ptr, m_err;
  int m_mode [4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_mask = 15; m_cmd = 0; m_ptr = 0; m_err = 0;
      foreach (m_mode[i]) m_mode[i] = 0;
    end else begin
      int n;
      n = wr_data & 3;
      m_err = 0;
      if (ptr_toggle) m_ptr = 1 - m_ptr;
      if (wr_en) begin
        case (wr_port)
          0: if ((wr_data & 8'hFB) != 0) m_err = 1; else m_cmd = wr_data;
          1: begin
               if (wr_data[2]) m_stat = m_stat | (1 << (n + 4));
               else m_stat = m_stat & ~(1 << (n + 4));
               m_stat = m_stat & ~(1 << n);
             end
          2: if (wr_data[2]) m_mask = m_mask | (1 << n); else m_mask = m_mask & ~(1 << n);
          3: m_mode[n] = wr_data;
          4: m_ptr = 0;
          5: begin m_ptr = 0; m_mask = 15; m_stat = 0; m_cmd = 0; end
          6: m_mask = 0;
          7: m_mask = wr_data & 15;
          default: ;
        endcase
      end
      m_stat = m_stat | tc_set;
      m_stat = (m_stat | (hold_req << 4)) & ~(release_req << 4) & 255;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R9 model status", status, m_stat);
    chk("R4 model mask", mask, m_mask);
    chk("R2 model command", command, m_cmd);
    chk("R6 model byte_ptr", byte_ptr, m_ptr);
    chk("R2 model cmd_err", cmd_err, m_err);
    for (int i = 0; i < 4; i++) chk("R5 model mode", mode_flat[8*i +: 8], m_mode[i]);
  end

  task automatic wr(int p, int d);
    @(negedge clk); wr_en = 1; wr_port = 3'(p); wr_data = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic strobe(int h, int r, int t, bit tg);
    @(negedge clk); hold_req = 4'(h); release_req = 4'(r); tc_set = 4'(t); ptr_toggle = tg;
    @(negedge clk); hold_req = 0; release_req = 0; tc_set = 0; ptr_toggle = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", status, 8'h00); chk("R1 mask", mask, 4'hF);
    chk("R1 command", command, 0); chk("R1 mode", mode_flat, 0);
    chk("R1 byte_ptr", byte_ptr, 0); chk("R1 cmd_err", cmd_err, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 mask after reset", mask, 4'hF);

    wr(0, 8'h04); chk("R2 accept", command, 8'h04);
    @(negedge clk); wr_en = 1; wr_port = 0; wr_data = 8'h05;
    @(negedge clk); wr_en = 0;
    chk("R2 err pulse", cmd_err, 1); chk("R2 keep", command, 8'h04);
    @(negedge clk); chk("R2 err drop", cmd_err, 0);
    wr(0, 8'h00); chk("R2 zero ok", command, 0);

    wr(1, 8'h06); chk("R3 set req", status, 8'h40);
    strobe(0, 0, 4'h4, 0); chk("R10 tc set", status, 8'h44);
    wr(1, 8'h02); chk("R3 clear req and tc", status, 8'h00);

    wr(6, 0); chk("R8 clear masks", mask, 4'h0);
    wr(2, 8'h05); chk("R4 mask ch1", mask, 4'h2);
    wr(2, 8'h07); chk("R4 mask ch3", mask, 4'hA);
    wr(2, 8'h01); chk("R4 unmask ch1", mask, 4'h8);

    wr(3, 8'h9B); chk("R5 mode ch3", mode_flat, 32'h9B00_0000);
    wr(3, 8'h54); chk("R5 mode ch0", mode_flat, 32'h9B00_0054);

    strobe(0, 0, 0, 1); chk("R6 toggle", byte_ptr, 1);
    @(negedge clk); wr_en = 1; wr_port = 4; ptr_toggle = 1;
    @(negedge clk); wr_en = 0; ptr_toggle = 0;
    chk("R6 clear beats toggle", byte_ptr, 0);

    strobe(4'h3, 0, 0, 0); chk("R9 hold", status, 8'h30);
    strobe(4'h1, 4'h1, 0, 0); chk("R9 release wins", status, 8'h20);
    @(negedge clk); wr_en = 1; wr_port = 1; wr_data = 8'h05; release_req = 4'h2;
    @(negedge clk); wr_en = 0; release_req = 0;
    chk("R9 release after write", status, 8'h00);

    wr(7, 8'hA5); chk("R8 write masks", mask, 4'h5);

    wr(0, 8'h04); strobe(4'h8, 0, 4'h1, 1);
    wr(5, 0);
    chk("R7 mask", mask, 4'hF); chk("R7 status", status, 0);
    chk("R7 command", command, 0); chk("R7 ptr", byte_ptr, 0);
    chk("R7 mode kept", mode_flat, 32'h9B00_0054);
    @(negedge clk); wr_en = 1; wr_port = 5; hold_req = 4'h4;
    @(negedge clk); wr_en = 0; hold_req = 0;
    chk("R9 hold after master reset", status, 8'h40);

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule